// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from on-chip peripheral lines and from external request pins and drives two active-low request lines toward a processor. The normal line `irq_n` serves every peripheral line and the external normal pins. The fast line `fiq_n` answers one dedicated external pin and nothing else. Each normal source has an enable bit, a trigger mode and a 3-bit priority. The controller picks the highest-priority eligible source and presents a handler address for it, so software does not poll.

Software services the normal line through two registers. Reading the vector register acknowledges the winner and pushes its priority onto an internal level stack. Writing the end-of-interrupt register pops that stack. While a handler runs, only a source with strictly higher priority can raise `irq_n` again, so handlers nest in priority order. Configuration uses a plain synchronous register port. Read data is registered and valid on the cycle after `rd_en`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_n` and `fiq_n` are high, and every register and latched pending bit is zero. This includes the enables, the modes, the priorities, the base and the spurious value.
- R2: `fiq_n` is driven only by `ext_fiq`, gated by enable bit 7 at address 16 and by the fast mode at address 17. Normal sources never drive `fiq_n`, and `ext_fiq` never drives `irq_n`. Reading address 21 returns base + 28 and clears a latched fast edge.
- R3: Enable bits 0..6 at address 16 mask sources 0..6. A source whose bit is 0 neither drives `irq_n` nor wins the vector.
- R4: Internal sources 0..3 use mode bit 4 of their configuration word: 0 means active while high, and 1 means a rising edge latches a pending bit.
- R5: External sources 4..6 (pins `ext_irq[0..2]`) use mode bits [5:4]: 00 high level, 01 rising edge, 10 low level, 11 falling edge.
- R6: A read of address 20 returns base (address 18) + 4 × index of the eligible source with the highest priority (bits [2:0] of configuration word 0..6).
- R7: Among eligible sources of equal top priority, the lowest index wins.
- R8: A vector read that finds a winner clears that winner's edge-pending bit and pushes its priority. `irq_n` then stays high until a strictly higher priority becomes active.
- R9: A write to address 22 pops one level. A lower-priority source blocked by a higher level becomes eligible once that level is popped.
- R10: A vector read with no eligible source returns the spurious value (address 19) and leaves the stack unchanged.
- R11: A level on an external pin reaches `irq_n` on the third rising clock edge after the pin changes. An internal level reaches it on the first edge.
- R12: Configuration words read back as {mode[1:0] at bits 5:4, priority at bits 2:0}. Mode bit 5 of an internal source always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src | input | N_INT | Peripheral request lines, synchronous to clk |
| ext_irq | input | N_EXT | External normal request pins, asynchronous |
| ext_fiq | input | 1 | External fast request pin, asynchronous |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | DW | Registered read data |
| irq_n | output | 1 | Normal request, active low |
| fiq_n | output | 1 | Fast request, active low |

## Verification
The stack assertions assume the bus never raises `rd_en` and `wr_en` together. The push and pop checks rely on that to separate a vector read from an end-of-interrupt write. The bench drives every access through tasks that assert exactly one strobe for one cycle. The bench also issues end-of-interrupt writes only after a successful vector read, so the stack never underflows. Peripheral lines change only at falling clock edges, which keeps them synchronous as the internal paths require.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_INT = 4,
  parameter int N_EXT = 3,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_INT-1:0] int_src,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             ext_fiq,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [DW-1:0]    rdata,
  output logic             irq_n,
  output logic             fiq_n
);
  localparam int NS  = N_INT + N_EXT;
  localparam int IW  = (NS > 1) ? $clog2(NS) : 1;
  localparam int PW  = 3;
  localparam int LV  = 1 << PW;
  localparam int SPW = $clog2(LV + 1);
  localparam int EW  = N_EXT + 1;
  localparam logic [AW-1:0] A_EN   = AW'(16);
  localparam logic [AW-1:0] A_FM   = AW'(17);
  localparam logic [AW-1:0] A_BASE = AW'(18);
  localparam logic [AW-1:0] A_SPUR = AW'(19);
  localparam logic [AW-1:0] A_VEC  = AW'(20);
  localparam logic [AW-1:0] A_FVEC = AW'(21);
  localparam logic [AW-1:0] A_EOI  = AW'(22);

  logic [EW-1:0]    s1, s2, s3;
  logic [N_INT-1:0] int_prev;
  logic [PW-1:0]    prio [NS];
  logic [1:0]       mode [NS];
  logic [NS:0]      en_r;
  logic [1:0]       fmode;
  logic [DW-1:0]    vbase, spur;
  logic [NS-1:0]    pend, lvl, hit, act;
  logic             fpend, flvl, fhit, fact;
  logic [PW-1:0]    stk [LV];
  logic [SPW-1:0]   sp, spm1;
  logic [PW-1:0]    top, best;
  logic [IW-1:0]    widx;
  logic             found;

  wire vec_rd  = rd_en && addr == A_VEC;
  wire fvec_rd = rd_en && addr == A_FVEC;
  wire eoi_wr  = wr_en && addr == A_EOI;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; int_prev <= '0;
    end else begin
      s1 <= {ext_fiq, ext_irq}; s2 <= s1; s3 <= s2; int_prev <= int_src;
    end

  for (genvar i = 0; i < NS; i++) begin : g_src
    if (i < N_INT) begin : g_int
      assign lvl[i] = int_src[i];
      assign hit[i] = int_src[i] & ~int_prev[i];
    end else begin : g_ext
      assign lvl[i] = s2[i-N_INT] ^ mode[i][1];
      assign hit[i] = mode[i][1] ? (s3[i-N_INT] & ~s2[i-N_INT])
                                 : (s2[i-N_INT] & ~s3[i-N_INT]);
    end
    assign act[i] = en_r[i] & (mode[i][0] ? pend[i] : lvl[i]);
  end

  assign flvl = s2[N_EXT] ^ fmode[1];
  assign fhit = fmode[1] ? (s3[N_EXT] & ~s2[N_EXT]) : (s2[N_EXT] & ~s3[N_EXT]);
  assign fact = en_r[NS] & (fmode[0] ? fpend : flvl);

  assign spm1 = sp - 1'b1;
  assign top  = stk[spm1[PW-1:0]];

  always_comb begin
    found = 1'b0;
    best  = '0;
    widx  = '0;
    for (int i = 0; i < NS; i++)
      if (act[i] && (sp == '0 || prio[i] > top) && (!found || prio[i] > best)) begin
        found = 1'b1;
        best  = prio[i];
        widx  = IW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_r <= '0; fmode <= '0; vbase <= '0; spur <= '0;
      for (int i = 0; i < NS; i++) begin prio[i] <= '0; mode[i] <= '0; end
    end else if (wr_en) begin
      for (int i = 0; i < NS; i++)
        if (addr == AW'(i)) begin
          prio[i] <= wdata[PW-1:0];
          mode[i] <= (i < N_INT) ? {1'b0, wdata[4]} : wdata[5:4];
        end
      case (addr)
        A_EN:   en_r  <= wdata[NS:0];
        A_FM:   fmode <= wdata[1:0];
        A_BASE: vbase <= wdata;
        A_SPUR: spur  <= wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= '0; fpend <= 1'b0;
    end else begin
      for (int i = 0; i < NS; i++) begin
        if (!mode[i][0] || (vec_rd && found && widx == IW'(i))) pend[i] <= 1'b0;
        if (mode[i][0] && hit[i]) pend[i] <= 1'b1;
      end
      if (!fmode[0] || fvec_rd) fpend <= 1'b0;
      if (fmode[0] && fhit) fpend <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sp <= '0;
    else if (vec_rd && found) sp <= sp + 1'b1;
    else if (eoi_wr && sp != '0) sp <= spm1;

  always_ff @(posedge clk)
    if (vec_rd && found) stk[sp[PW-1:0]] <= best;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      rdata <= '0;
      for (int i = 0; i < NS; i++)
        if (addr == AW'(i)) rdata <= DW'({mode[i], 1'b0, prio[i]});
      case (addr)
        A_EN:   rdata <= DW'(en_r);
        A_FM:   rdata <= DW'(fmode);
        A_BASE: rdata <= vbase;
        A_SPUR: rdata <= spur;
        A_VEC:  rdata <= found ? vbase + DW'({widx, 2'b00}) : spur;
        A_FVEC: rdata <= vbase + DW'(NS * 4);
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_n <= 1'b1; fiq_n <= 1'b1;
    end else begin
      irq_n <= ~found; fiq_n <= ~fact;
    end
endmodule

module irq_vector_ctrl_chk #(
  parameter int NS  = 7,
  parameter int SPW = 4,
  parameter int LV  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_n,
  input logic           fiq_n,
  input logic [NS:0]    en_r,
  input logic [SPW-1:0] sp,
  input logic           found,
  input logic           vec_rd,
  input logic           eoi_wr
);
  // R1
  rst_idle_chk: assert property (@(posedge clk) !rst_n |=> (irq_n && fiq_n));
  // R2
  fast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_n |-> $past(en_r[NS]));
  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(|en_r[NS-1:0]));
  // R8
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && found) |=> sp == $past(sp) + 1'b1);
  // R9
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !vec_rd && sp != '0) |=> sp == $past(sp) - 1'b1);
  // R9
  depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(LV));
  // R10
  spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !found && !eoi_wr) |=> $stable(sp));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NS(NS), .SPW(SPW), .LV(LV)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .fiq_n(fiq_n), .en_r(en_r),
  .sp(sp), .found(found), .vec_rd(vec_rd), .eoi_wr(eoi_wr)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  int_src = '0;
  logic [2:0]  ext_irq = '0;
  logic        ext_fiq = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] rdata;
  logic        irq_n, fiq_n;
  int n_chk = 0, n_bad = 0;
  logic [31:0] v;

  localparam logic [31:0] BASE = 32'h1000, SPUR = 32'hDEAD;

  irq_vector_ctrl u0 (.clk(clk), .rst_n(rst_n), .int_src(int_src), .ext_irq(ext_irq),
    .ext_fiq(ext_fiq), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .irq_n(irq_n), .fiq_n(fiq_n));

  always #5 clk = ~clk;

  // {int_src, ext_irq, expected irq_n, expected vector}
  localparam logic [23:0] TBL [9] = '{
    {4'b0000, 3'b100, 1'b1, 16'hDEAD},
    {4'b0001, 3'b100, 1'b0, 16'h1000},
    {4'b0110, 3'b100, 1'b0, 16'h1004},
    {4'b1001, 3'b100, 1'b0, 16'h1000},
    {4'b0000, 3'b101, 1'b0, 16'h1010},
    {4'b0000, 3'b000, 1'b0, 16'h1018},
    {4'b0100, 3'b000, 1'b0, 16'h1008},
    {4'b1000, 3'b110, 1'b0, 16'h1014},
    {4'b0111, 3'b001, 1'b0, 16'h1010}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    settle(3); rst_n = 1; settle(1);
    chk("R1 irq_n", {31'd0, irq_n}, 1);
    chk("R1 fiq_n", {31'd0, fiq_n}, 1);
    rd(16, v); chk("R1 enable", v, 0);
    rd(19, v); chk("R1 spurious", v, 0);
    rd(3, v);  chk("R1 cfg3", v, 0);

    wr(0, 32'h02); wr(1, 32'h05); wr(2, 32'h05); wr(3, 32'h01);
    wr(4, 32'h06); wr(5, 32'h03); wr(6, 32'h25);
    wr(18, BASE); wr(19, SPUR);
    ext_irq = 3'b100;
    wr(16, 32'h7F);

    rd(6, v); chk("R12 cfg6", v, 32'h25);
    wr(0, 32'h31); rd(0, v); chk("R12 internal mode bit", v, 32'h11);
    wr(0, 32'h02);

    for (int k = 0; k < 9; k++) begin
      int_src = TBL[k][23:20]; ext_irq = TBL[k][19:17];
      settle(5);
      chk("R6/R7 table irq_n", {31'd0, irq_n}, {31'd0, TBL[k][16]});
      rd(20, v);
      chk("R6/R7 table vector", v, {16'd0, TBL[k][15:0]});
      if (TBL[k][15:0] != 16'hDEAD) wr(22, 0);
    end
    int_src = 0; ext_irq = 3'b100; settle(4);

    // R2 fast path isolation
    int_src = 4'b1111; ext_irq = 3'b011; settle(5);
    chk("R2 normal does not drive fiq_n", {31'd0, fiq_n}, 1);
    int_src = 0; ext_irq = 3'b100; ext_fiq = 1; settle(5);
    chk("R2 fast disabled", {31'd0, fiq_n}, 1);
    chk("R2 fast does not drive irq_n", {31'd0, irq_n}, 1);
    wr(16, 32'hFF); settle(2);
    chk("R2 fast level", {31'd0, fiq_n}, 0);
    rd(21, v); chk("R2 fast vector", v, BASE + 28);
    ext_fiq = 0; settle(5);
    chk("R2 fast released", {31'd0, fiq_n}, 1);
    wr(17, 1);
    ext_fiq = 1; settle(1); ext_fiq = 0; settle(5);
    chk("R2 fast edge latched", {31'd0, fiq_n}, 0);
    rd(21, v); settle(2);
    chk("R2 fast edge cleared", {31'd0, fiq_n}, 1);

    // R3 masking
    wr(16, 32'hFD); int_src = 4'b0010; settle(4);
    chk("R3 masked irq_n", {31'd0, irq_n}, 1);
    rd(20, v); chk("R3 masked vector", v, SPUR);
    wr(16, 32'hFF); settle(2);
    chk("R3 unmasked irq_n", {31'd0, irq_n}, 0);
    rd(20, v); chk("R3 unmasked vector", v, BASE + 4);
    wr(22, 0); int_src = 0; settle(3);

    // R4 internal rising edge
    wr(0, 32'h12);
    int_src = 4'b0001; settle(1); int_src = 0; settle(4);
    chk("R4 edge latched", {31'd0, irq_n}, 0);
    rd(20, v); chk("R4 edge vector", v, BASE);
    wr(22, 0); settle(3);
    chk("R8 edge pending cleared", {31'd0, irq_n}, 1);
    wr(0, 32'h02);

    // R5 external falling edge
    wr(5, 32'h33);
    ext_irq = 3'b110; settle(5);
    chk("R5 rising ignored in falling mode", {31'd0, irq_n}, 1);
    ext_irq = 3'b100; settle(5);
    chk("R5 falling edge latched", {31'd0, irq_n}, 0);
    rd(20, v); chk("R5 falling vector", v, BASE + 20);
    wr(22, 0); settle(3);
    chk("R5 falling cleared", {31'd0, irq_n}, 1);
    wr(5, 32'h03);

    // R8/R9 nesting
    int_src = 4'b1000; settle(3);
    rd(20, v); chk("R8 first vector", v, BASE + 12);
    settle(2); chk("R8 same level blocked", {31'd0, irq_n}, 1);
    int_src = 4'b1010; settle(3);
    chk("R9 higher preempts", {31'd0, irq_n}, 0);
    rd(20, v); chk("R9 nested vector", v, BASE + 4);
    int_src = 4'b1011; settle(3);
    chk("R9 lower blocked", {31'd0, irq_n}, 1);
    int_src = 4'b1001; wr(22, 0); settle(2);
    chk("R9 unblocked after pop", {31'd0, irq_n}, 0);
    rd(20, v); chk("R9 unblocked vector", v, BASE);
    wr(22, 0); wr(22, 0); int_src = 0; settle(3);

    // R10 spurious does not push
    int_src = 4'b1000; settle(3);
    rd(20, v); chk("R10 winner", v, BASE + 12);
    rd(20, v); chk("R10 spurious value", v, SPUR);
    wr(22, 0); settle(2);
    chk("R10 one pop suffices", {31'd0, irq_n}, 0);
    rd(20, v); wr(22, 0); int_src = 0; settle(3);

    // R11 latency
    @(negedge clk); ext_irq = 3'b101;
    @(negedge clk); chk("R11 ext edge1", {31'd0, irq_n}, 1);
    @(negedge clk); chk("R11 ext edge2", {31'd0, irq_n}, 1);
    @(negedge clk); chk("R11 ext edge3", {31'd0, irq_n}, 0);
    rd(20, v); wr(22, 0); ext_irq = 3'b100; settle(4);
    @(negedge clk); int_src = 4'b0001;
    @(negedge clk); chk("R11 internal edge1", {31'd0, irq_n}, 0);
    rd(20, v); wr(22, 0); int_src = 0; settle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule